// File: doc/BRIEF.md
# Windowed and Paged Address Translator

This block sits between a 16-bit CPU and the memory decoders of a machine with banked extended RAM. Each CPU address is translated in the same cycle into a region code and a real address of up to 20 bits. When neither translation applies, the block reports a fall-through, and a separate fixed decoder then handles the address. It uses two translation mechanisms. The first is a 1 KB relocation window at 0x7C00–0x7FFF, moved by an 8-bit offset into the first 64 KB page of extended RAM. The second is a page translator with sixteen bank registers, one for each 4 KB slice of the CPU space.

Some bank values point back into the standard 64 KB map and are then decoded by the fixed decoder. One bank group opens a direct path into video memory. Bank values whose page number is beyond the installed extended RAM land on an open bus region, which reads as 0xFF. The bank registers are loaded through a simple indexed write port.

Top module: `win_page_xlate`

## Requirements
- R1: When `winEn` is high and `cpuAddr` is in 0x7C00..0x7FFF, `region` is 1 (extended RAM) and `realAddr` is ((`winOffset` << 8) + `cpuAddr`) mod 0x10000, with bits 19:16 zero.
- R2: An address outside 0x7C00..0x7FFF, or any address while `winEn` is low, gets no window translation.
- R3: A window hit takes priority over page translation for the same address.
- R4: On a rising clock edge with `bankWe` high, `bankWdata` is stored in bank register `bankSel`. The register that applies to an access is the one selected by `cpuAddr[15:12]`, and a write takes effect from the next cycle.
- R5: With paging enabled and no window hit, addresses 0xFC00..0xFFFF are never paged: `region` is 0 (fixed), `fixedReq` is 1 and `realAddr` equals `cpuAddr`.
- R6: A bank value of 0x30..0x3E gives `region` 0 and `fixedReq` 1, with `realAddr` = (bank[3:0] << 12) | `cpuAddr[11:0]`. A bank value of 0x3F leaves `cpuAddr` unchanged on `realAddr` with `region` 0.
- R7: A bank value with upper nibble 1 gives `region` 2 (video direct access) with `realAddr` = (bank[3:0] << 12) | `cpuAddr[11:0]`.
- R8: Any other bank value has page number bank[7:4]. If that page number is below `EXT_PAGES`, `region` is 1 and `realAddr` = {bank, `cpuAddr[11:0]`}. Otherwise `region` is 3 (open bus, reads 0xFF) and `realAddr` is 0.
- R9: With `pageEn` low and no window hit, `region` is 0, `fixedReq` is 1 and `realAddr` equals `cpuAddr`.
- R10: After reset, bank register i holds 0x30 + i, so paging starts as the identity map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank registers |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuAddr | input | 16 | CPU address to translate |
| winEn | input | 1 | Relocation window enable |
| winOffset | input | 8 | Window offset in 256-byte units |
| pageEn | input | 1 | Page translator enable |
| bankWe | input | 1 | Bank register write strobe |
| bankSel | input | 4 | Bank register index to write |
| bankWdata | input | 8 | Bank value to write |
| region | output | 2 | 0 fixed, 1 extended RAM, 2 video, 3 open bus |
| realAddr | output | 20 | Translated address |
| fixedReq | output | 1 | High when the fixed decoder must handle the access |

## Verification
The hardest point to reach from the ports is the boundary between installed and missing extended pages. The bench therefore builds the block with fewer pages than the default. It writes every one of the 256 bank values in turn into the slot that its low nibble selects, then reads that slot at its lowest, a middle and its highest offset. This walks every page number past the limit, passes through the fold-back and video groups, and in slice 15 runs into the untranslated top 1 KB. The window is swept over all offsets while paging is enabled, so that its priority and its 16-bit wrap are both exercised.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    RG_FIXED  = 2'd0,
    RG_EXTRAM = 2'd1,
    RG_VIDEO  = 2'd2,
    RG_OPEN   = 2'd3
  } region_e;

  // strobes from control to datapath; at most one set per access
  typedef struct packed {
    logic winHit;
    logic extHit;
    logic videoHit;
    logic openHit;
    logic remapHit;
  } xl_strobe_t;
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int BANK_W    = 8,
  parameter int EXT_PAGES = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cpuAddr,
  input  logic              winEn,
  input  logic              pageEn,
  input  logic [BANK_W-1:0] curBank,
  output xl_strobe_t        strb,
  output region_e           region
);
  localparam int PG_W = BANK_W - 4;
  localparam logic [PG_W:0] PAGE_LIM = (PG_W+1)'(EXT_PAGES);

  logic            winZone;
  logic            highZone;
  logic [PG_W-1:0] pageNum;

  assign winZone  = (cpuAddr[15:10] == 6'b011111);
  assign highZone = (cpuAddr[15:10] == 6'b111111);
  assign pageNum  = curBank[BANK_W-1:4];

  always_comb begin
    strb   = '0;
    region = RG_FIXED;
    if (winEn && winZone) begin
      strb.winHit = 1'b1;
      region      = RG_EXTRAM;
    end else if (pageEn && !highZone) begin
      if (pageNum == PG_W'(3)) begin
        // fold back into the standard map; 0xF keeps the CPU address
        strb.remapHit = (curBank[3:0] != 4'hF);
      end else if (pageNum == PG_W'(1)) begin
        strb.videoHit = 1'b1;
        region        = RG_VIDEO;
      end else if ({1'b0, pageNum} >= PAGE_LIM) begin
        strb.openHit = 1'b1;
        region       = RG_OPEN;
      end else begin
        strb.extHit = 1'b1;
        region      = RG_EXTRAM;
      end
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R3

  AST_WIN_BEATS_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (winEn && winZone) |-> !strb.extHit && !strb.videoHit && !strb.openHit && !strb.remapHit); // R3
endmodule

// File: rtl/xlate_bank_dp.sv
module xlate_bank_dp
  import xlate_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int SLOTS  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [15:0]          cpuAddr,
  input  logic [7:0]           winOffset,
  input  logic                 bankWe,
  input  logic [3:0]           bankSel,
  input  logic [BANK_W-1:0]    bankWdata,
  input  xl_strobe_t           strb,
  output logic [BANK_W-1:0]    curBank,
  output logic [BANK_W+11:0]   realAddr
);
  localparam int REAL_W = BANK_W + 12;
  localparam int IDENT  = 8'h30;

  logic [BANK_W-1:0] bankReg [SLOTS];
  logic [15:0]       winSum;
  logic [11:0]       pageOff;

  for (genvar i = 0; i < SLOTS; i++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bankReg[i] <= BANK_W'(IDENT + i);
      else if (bankWe && (bankSel == 4'(i)))
        bankReg[i] <= bankWdata;
    end
  end

  assign curBank = bankReg[cpuAddr[15:12]];
  assign pageOff = cpuAddr[11:0];
  assign winSum  = {winOffset, 8'h00} + cpuAddr;

  always_comb begin
    if (strb.winHit)
      realAddr = REAL_W'(winSum);
    else if (strb.extHit)
      realAddr = {curBank, pageOff};
    else if (strb.videoHit || strb.remapHit)
      realAddr = REAL_W'({curBank[3:0], pageOff});
    else if (strb.openHit)
      realAddr = '0;
    else
      realAddr = REAL_W'(cpuAddr);
  end

  AST_BANK_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    bankWe |=> (bankReg[$past(bankSel)] == $past(bankWdata))); // R4

  AST_WIN_LOW_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.winHit |-> (realAddr[REAL_W-1:16] == '0)); // R1
endmodule

// File: rtl/win_page_xlate.sv
module win_page_xlate
  import xlate_pkg::*;
#(
  parameter int BANK_W    = 8,
  parameter int EXT_PAGES = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [15:0]          cpuAddr,
  input  logic                 winEn,
  input  logic [7:0]           winOffset,
  input  logic                 pageEn,
  input  logic                 bankWe,
  input  logic [3:0]           bankSel,
  input  logic [BANK_W-1:0]    bankWdata,
  output logic [1:0]           region,
  output logic [BANK_W+11:0]   realAddr,
  output logic                 fixedReq
);
  localparam int SLOTS = 16;

  xl_strobe_t        strb;
  region_e           regionE;
  logic [BANK_W-1:0] curBank;

  initial begin
    if (EXT_PAGES < 1 || EXT_PAGES > 12) $error("EXT_PAGES out of range");
  end

  xlate_ctrl #(.BANK_W(BANK_W), .EXT_PAGES(EXT_PAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .winEn(winEn),
    .pageEn(pageEn), .curBank(curBank), .strb(strb), .region(regionE)
  );

  xlate_bank_dp #(.BANK_W(BANK_W), .SLOTS(SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .winOffset(winOffset),
    .bankWe(bankWe), .bankSel(bankSel), .bankWdata(bankWdata),
    .strb(strb), .curBank(curBank), .realAddr(realAddr)
  );

  assign region   = regionE;
  assign fixedReq = (regionE == RG_FIXED);

  AST_HIGH_UNPAGED: assert property (@(posedge clk) disable iff (!rstN)
    (!winEn && cpuAddr >= 16'hFC00) |-> (fixedReq && realAddr == (BANK_W+12)'(cpuAddr))); // R5

  AST_PAGING_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!pageEn && !winEn) |-> (fixedReq && realAddr == (BANK_W+12)'(cpuAddr))); // R9

  AST_OPEN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (region == 2'd3) |-> (realAddr == '0 && pageEn)); // R8
endmodule

// File: tb/win_page_xlate_test.sv
module win_page_xlate_test;
  localparam int PERIOD = 10;
  localparam int PAGES  = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        winEn = 1'b0;
  logic [7:0]  winOffset = '0;
  logic        pageEn = 1'b0;
  logic        bankWe = 1'b0;
  logic [3:0]  bankSel = '0;
  logic [7:0]  bankWdata = '0;
  logic [1:0]  region;
  logic [19:0] realAddr;
  logic        fixedReq;

  int checks = 0;
  int errors = 0;
  logic [7:0] shadow [16];

  always #(PERIOD/2) clk = ~clk;

  win_page_xlate #(.BANK_W(8), .EXT_PAGES(PAGES)) uut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .winEn(winEn),
    .winOffset(winOffset), .pageEn(pageEn), .bankWe(bankWe),
    .bankSel(bankSel), .bankWdata(bankWdata), .region(region),
    .realAddr(realAddr), .fixedReq(fixedReq)
  );

  // expected {region, realAddr} from the requirements
  function automatic logic [21:0] model(input logic [15:0] a, input logic we,
                                        input logic [7:0] wo, input logic pe);
    logic [7:0]  b;
    logic [15:0] s;
    b = shadow[a[15:12]];
    if (we && a >= 16'h7C00 && a <= 16'h7FFF) begin
      s = 16'((int'(wo) * 256 + int'(a)) % 65536);
      return {2'd1, 4'h0, s};
    end
    if (!pe || a >= 16'hFC00) return {2'd0, 4'h0, a};
    if (b[7:4] == 4'd3) begin
      if (b[3:0] == 4'hF) return {2'd0, 4'h0, a};
      return {2'd0, 4'h0, b[3:0], a[11:0]};
    end
    if (b[7:4] == 4'd1) return {2'd2, 4'h0, b[3:0], a[11:0]};
    if (int'(b[7:4]) >= PAGES) return {2'd3, 20'h0};
    return {2'd1, b, a[11:0]};
  endfunction

  task automatic probe(input string req, input logic [15:0] a, input logic we,
                       input logic [7:0] wo, input logic pe);
    logic [21:0] exp;
    @(negedge clk);
    cpuAddr = a; winEn = we; winOffset = wo; pageEn = pe;
    #1;
    exp = model(a, we, wo, pe);
    checks++;
    if ({region, realAddr} !== exp || fixedReq !== (exp[21:20] == 2'd0)) begin
      errors++;
      $display("FAIL %s addr=%h got region=%0d real=%h fixed=%b exp region=%0d real=%h",
               req, a, region, realAddr, fixedReq, exp[21:20], exp[19:0]);
    end
  endtask

  task automatic writeBank(input logic [3:0] sel, input logic [7:0] val);
    @(negedge clk);
    bankWe = 1'b1; bankSel = sel; bankWdata = val;
    @(negedge clk);
    bankWe = 1'b0;
    shadow[sel] = val;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = 8'(8'h30 + i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 identity after reset, plus R5 top region
    for (int s = 0; s < 16; s++) begin
      probe("R10", {4'(s), 12'h000}, 1'b0, 8'h00, 1'b1);
      probe("R10", {4'(s), 12'hBFF}, 1'b0, 8'h00, 1'b1);
      probe("R10", {4'(s), 12'hFFF}, 1'b0, 8'h00, 1'b1);
    end

    // R4 R6 R7 R8: every bank value into the slot its low nibble selects
    for (int v = 0; v < 256; v++) begin
      writeBank(4'(v), 8'(v));
      probe("R4", {4'(v), 12'h000}, 1'b0, 8'h00, 1'b1);
      probe("R8", {4'(v), 12'h5A3}, 1'b0, 8'h00, 1'b1);
      probe("R6", {4'(v), 12'hFFF}, 1'b0, 8'h00, 1'b1);
      probe("R7", {4'(v), 12'hBFF}, 1'b0, 8'h00, 1'b1);
    end

    // R5: top 1 KB with a paging value in slot 15
    writeBank(4'hF, 8'h02);
    for (int a = 16'hFC00; a <= 16'hFFFF; a += 16'h3F) probe("R5", 16'(a), 1'b0, 8'h00, 1'b1);
    probe("R5", 16'hFBFF, 1'b0, 8'h00, 1'b1);

    // R9: paging disabled ignores banks
    for (int s = 0; s < 16; s++) writeBank(4'(s), 8'(8'h50 + s));
    for (int a = 0; a < 65536; a += 997) probe("R9", 16'(a), 1'b0, 8'h00, 1'b0);

    // R1 R3: window over all offsets with paging on
    for (int o = 0; o < 256; o++) begin
      probe("R1", 16'h7C00, 1'b1, 8'(o), 1'b1);
      probe("R3", 16'h7FFF, 1'b1, 8'(o), 1'b1);
      probe("R1", 16'(16'h7C00 + (o * 3) % 1024), 1'b1, 8'(o), 1'b0);
    end

    // R2: window edges and disabled window
    probe("R2", 16'h7BFF, 1'b1, 8'hA5, 1'b1);
    probe("R2", 16'h8000, 1'b1, 8'hA5, 1'b1);
    probe("R2", 16'h7BFF, 1'b1, 8'hA5, 1'b0);
    probe("R2", 16'h7D00, 1'b0, 8'hA5, 1'b1);
    probe("R2", 16'h7D00, 1'b0, 8'hA5, 1'b0);

    // R10 again after a second reset
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < 16; i++) shadow[i] = 8'(8'h30 + i);
    for (int s = 0; s < 16; s++) probe("R10", {4'(s), 12'h321}, 1'b0, 8'h00, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule